// File: doc/BRIEF.md
# Floating-Point Register Specifier Decoder with Lazy Half Tracking

This block turns the three 5-bit register fields of a floating-point operation into physical word indices for a register file of 64 words of 32 bits. For each operand the caller supplies a size code: none, single, double or quad. Single operands use the field unchanged. Double and quad operands use the low field bit to select the upper bank, which doubles the reachable space. Quad operands whose field has bit 1 set are illegal. Such a request is aborted and raises an invalid-register trap code.

The block also tracks which halves of the register file hold live data. It keeps a lower-half dirty bit, an upper-half dirty bit and a floating-point enable bit. A source that lives in a half never written reads as zero, so the register array need not be read. The first write after the unit is enabled clears the graphics status register and drops any stale dirty marks. A write into a clean half asks the storage to zero all 32 words of that half, then marks the half dirty. The register array and the arithmetic stay outside the block.

Requests arrive on a valid/ready stream and leave as one registered response per accepted request, in order. `req_ready` is high when the output stage is empty or is being drained in the same cycle. A response stays on the output with all of its fields unchanged until `rsp_ready` takes it. Accepted requests update the half-tracking state at once, so the next request already sees the effect of the previous write. The status pins are plain levels.

Top module: `fpr_spec_decode`

## Requirements
- R1: The destination field is `req_insn[29:25]`, the first source field is `req_insn[18:14]` and the second source field is `req_insn[4:0]`.
- R2: Size codes are 0 none, 1 single, 2 double and 3 quad. For a single the index is {0, field}. For a double or quad it is {field[0], field[4:1], 0}, so a field with bit 0 set lands at index 32 or above.
- R3: Any quad operand whose field has bit 1 set sets `rsp_err` and sets `trap_type` to 6. In that case the response has no write, no clear requests and no read-zero flags, and the enable and dirty bits stay unchanged.
- R4: Each accepted request without an error sets `trap_type` to 0.
- R5: A source with index below 32 uses the lower dirty bit; any other index uses the upper dirty bit. A used source whose half bit is clear, taken from the state before this request's own write, gets its read-zero flag set.
- R6: A destination write while `fp_en` is 0 sets `rsp_gfx_clr`, clears both dirty bits and sets `fp_en`, before the half handling of R7.
- R7: A destination write into a half whose dirty bit is clear (after R6) raises that half's clear request and sets its dirty bit. A write into a dirty half raises no clear request.
- R8: An operand with size code 0 gives index 0, no read-zero flag, no write and no error.
- R9: `req_ready` is `!rsp_valid || rsp_ready`. Every accepted request yields exactly one response, in order. A response not taken is held stable.
- R10: After reset, `rsp_valid`, `fp_en`, both dirty bits and `trap_type` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_insn | input | 32 | Operation word holding the three register fields |
| req_sz_rs1 | input | 2 | Size code of the first source |
| req_sz_rs2 | input | 2 | Size code of the second source |
| req_sz_rd | input | 2 | Size code of the destination |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rs1_idx | output | 6 | Physical index of the first source |
| rsp_rs2_idx | output | 6 | Physical index of the second source |
| rsp_rd_idx | output | 6 | Physical index of the destination |
| rsp_rs1_zero | output | 1 | First source reads as zero |
| rsp_rs2_zero | output | 1 | Second source reads as zero |
| rsp_rd_we | output | 1 | Destination write is allowed |
| rsp_clr_lo | output | 1 | Zero the lower 32 words before the write |
| rsp_clr_hi | output | 1 | Zero the upper 32 words before the write |
| rsp_gfx_clr | output | 1 | Clear the graphics status register |
| rsp_err | output | 1 | Request aborted on an invalid register |
| trap_type | output | 3 | Trap code of the last accepted request |
| fp_en | output | 1 | Floating-point enable bit |
| dirty_lo | output | 1 | Lower half holds written data |
| dirty_hi | output | 1 | Upper half holds written data |

## Verification
The hardest case to reach is a write arriving while the unit is not enabled but a half looks dirty. From the ports this state cannot exist after reset, because the enable bit never falls again. The stimulus therefore stresses the neighbouring orderings instead. It makes an early first write to each bank, runs aborted quad requests between writes to show that they leave the state alone, and places back-to-back writes under random back-pressure. Together these confirm that each request sees the state left by the one before it, even while its own response is still stalled.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int FLD_W   = 5;
  localparam int IDX_W   = FLD_W + 1;
  localparam int TT_W    = 3;
  localparam int NSPEC   = 3;
  localparam int RS1_LSB = 14;
  localparam int RS2_LSB = 0;
  localparam int RD_LSB  = 25;
  localparam logic [TT_W-1:0] TT_NONE    = '0;
  localparam logic [TT_W-1:0] TT_BAD_REG = TT_W'(6);

  typedef enum logic [1:0] {
    SZ_NONE   = 2'd0,
    SZ_SINGLE = 2'd1,
    SZ_DOUBLE = 2'd2,
    SZ_QUAD   = 2'd3
  } opsz_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             used;
    logic             upper;
    logic             bad;
  } spec_t;

  typedef struct packed {
    logic [IDX_W-1:0] rs1_idx;
    logic [IDX_W-1:0] rs2_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             rs1_zero;
    logic             rs2_zero;
    logic             rd_we;
    logic             clr_lo;
    logic             clr_hi;
    logic             gfx_clr;
    logic             err;
  } rsp_t;
endpackage

// File: rtl/fpr_spec_map.sv
module fpr_spec_map
  import fpr_pkg::*;
(
  input  logic [FLD_W-1:0] fld,
  input  opsz_e            sz,
  output spec_t            spec
);
  always_comb begin
    spec = '0;
    unique case (sz)
      SZ_SINGLE: begin
        spec.used = 1'b1;
        spec.idx  = {1'b0, fld};
      end
      SZ_DOUBLE, SZ_QUAD: begin
        spec.used = 1'b1;
        spec.idx  = {fld[0], fld[FLD_W-1:1], 1'b0};
        spec.bad  = (sz == SZ_QUAD) && fld[1];
      end
      default: spec.used = 1'b0;
    endcase
    spec.upper = spec.idx[IDX_W-1];
  end
endmodule

// File: rtl/fpr_half_state.sv
module fpr_half_state (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_upper,
  input  logic commit,
  output logic fp_en,
  output logic dirty_lo,
  output logic dirty_hi,
  output logic clr_lo,
  output logic clr_hi,
  output logic gfx_clr
);
  logic base_lo, base_hi;

  always_comb begin
    base_lo = fp_en & dirty_lo;
    base_hi = fp_en & dirty_hi;
    gfx_clr = wr & ~fp_en;
    clr_lo  = wr & ~wr_upper & ~base_lo;
    clr_hi  = wr &  wr_upper & ~base_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_en    <= 1'b0;
      dirty_lo <= 1'b0;
      dirty_hi <= 1'b0;
    end else if (commit) begin
      fp_en    <= 1'b1;
      dirty_lo <= base_lo | clr_lo;
      dirty_hi <= base_hi | clr_hi;
    end
  end

  assert_enable_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> fp_en);
  assert_lo_dirty_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && clr_lo) |=> dirty_lo);
  assert_hi_dirty_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && clr_hi) |=> dirty_hi);
endmodule

// File: rtl/fpr_rsp_stage.sv
module fpr_rsp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/fpr_spec_decode.sv
module fpr_spec_decode
  import fpr_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [INSN_W-1:0] req_insn,
  input  logic [1:0]        req_sz_rs1,
  input  logic [1:0]        req_sz_rs2,
  input  logic [1:0]        req_sz_rd,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [5:0]        rsp_rs1_idx,
  output logic [5:0]        rsp_rs2_idx,
  output logic [5:0]        rsp_rd_idx,
  output logic              rsp_rs1_zero,
  output logic              rsp_rs2_zero,
  output logic              rsp_rd_we,
  output logic              rsp_clr_lo,
  output logic              rsp_clr_hi,
  output logic              rsp_gfx_clr,
  output logic              rsp_err,
  output logic [2:0]        trap_type,
  output logic              fp_en,
  output logic              dirty_lo,
  output logic              dirty_hi
);
  localparam int RSP_W = $bits(rsp_t);

  logic [1:0]  sz_arr [NSPEC];
  spec_t       sp     [NSPEC];
  logic        abort, wr, accept, commit;
  logic        clr_lo, clr_hi, gfx_clr;
  logic [NSPEC-1:0] src_zero;
  rsp_t        nxt, cur;
  logic [RSP_W-1:0] cur_bits;
  logic [TT_W-1:0]  trap_q;

  assign sz_arr[0] = req_sz_rs1;
  assign sz_arr[1] = req_sz_rs2;
  assign sz_arr[2] = req_sz_rd;

  for (genvar g = 0; g < NSPEC; g++) begin : g_spec
    localparam int LSB = (g == 0) ? RS1_LSB : (g == 1) ? RS2_LSB : RD_LSB;
    fpr_spec_map u_map (
      .fld  (req_insn[LSB +: FLD_W]),
      .sz   (opsz_e'(sz_arr[g])),
      .spec (sp[g])
    );
    assign src_zero[g] = sp[g].used & ~abort &
                         ~(sp[g].upper ? dirty_hi : dirty_lo);
  end

  always_comb begin
    abort = 1'b0;
    for (int i = 0; i < NSPEC; i++) abort = abort | sp[i].bad;
  end

  assign wr     = sp[2].used & ~abort;
  assign accept = req_valid & req_ready;
  assign commit = accept & wr;

  fpr_half_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .wr_upper (sp[2].upper),
    .commit   (commit),
    .fp_en    (fp_en),
    .dirty_lo (dirty_lo),
    .dirty_hi (dirty_hi),
    .clr_lo   (clr_lo),
    .clr_hi   (clr_hi),
    .gfx_clr  (gfx_clr)
  );

  always_comb begin
    nxt          = '0;
    nxt.rs1_idx  = sp[0].idx;
    nxt.rs2_idx  = sp[1].idx;
    nxt.rd_idx   = sp[2].idx;
    nxt.rs1_zero = src_zero[0];
    nxt.rs2_zero = src_zero[1];
    nxt.rd_we    = wr;
    nxt.clr_lo   = clr_lo;
    nxt.clr_hi   = clr_hi;
    nxt.gfx_clr  = gfx_clr;
    nxt.err      = abort;
  end

  fpr_rsp_stage #(.W(RSP_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (nxt),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (cur_bits)
  );

  assign cur = rsp_t'(cur_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= TT_NONE;
    else if (accept) trap_q <= abort ? TT_BAD_REG : TT_NONE;
  end

  assign trap_type    = trap_q;
  assign rsp_rs1_idx  = cur.rs1_idx;
  assign rsp_rs2_idx  = cur.rs2_idx;
  assign rsp_rd_idx   = cur.rd_idx;
  assign rsp_rs1_zero = cur.rs1_zero;
  assign rsp_rs2_zero = cur.rs2_zero;
  assign rsp_rd_we    = cur.rd_we;
  assign rsp_clr_lo   = cur.clr_lo;
  assign rsp_clr_hi   = cur.clr_hi;
  assign rsp_gfx_clr  = cur.gfx_clr;
  assign rsp_err      = cur.err;

  assert_abort_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && abort) |=> $stable({fp_en, dirty_lo, dirty_hi}));
  assert_err_no_side_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!rsp_rd_we && !rsp_clr_lo && !rsp_clr_hi && !rsp_gfx_clr));
  assert_written_half_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rd_we) |-> (fp_en && (rsp_rd_idx[5] ? dirty_hi : dirty_lo)));
endmodule

// File: tb/test_fpr_spec_decode.sv
module test_fpr_spec_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [31:0] req_insn = '0;
  logic [1:0]  req_sz_rs1 = '0, req_sz_rs2 = '0, req_sz_rd = '0;
  logic [5:0]  rsp_rs1_idx, rsp_rs2_idx, rsp_rd_idx;
  logic        rsp_rs1_zero, rsp_rs2_zero, rsp_rd_we, rsp_clr_lo, rsp_clr_hi;
  logic        rsp_gfx_clr, rsp_err, fp_en, dirty_lo, dirty_hi;
  logic [2:0]  trap_type;

  fpr_spec_decode i_fpr_spec_decode (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, bp_on = 0;

  // behavioural reference state
  bit m_en, m_lo, m_hi, m_acc, e_valid;
  int m_trap;
  int e_i1, e_i2, e_id;
  bit e_z1, e_z2, e_we, e_clo, e_chi, e_gfx, e_err;

  function automatic int map_idx(int f, int sz);
    if (sz == 0) return 0;
    if (sz == 1) return f;
    return (f % 2) * 32 + (f / 2) * 2;
  endfunction

  function automatic bit is_bad(int f, int sz);
    return sz == 3 && ((f / 2) % 2 == 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    m_acc = 0;
    if (!rst_n) begin
      m_en = 0; m_lo = 0; m_hi = 0; m_trap = 0; e_valid = 0;
    end else if (req_valid && (!e_valid || rsp_ready)) begin
      int f1, f2, fd, s1, s2, sd;
      bit up;
      m_acc = 1;
      f1 = int'(req_insn[18:14]); f2 = int'(req_insn[4:0]); fd = int'(req_insn[29:25]);
      s1 = int'(req_sz_rs1); s2 = int'(req_sz_rs2); sd = int'(req_sz_rd);
      e_valid = 1;
      e_i1 = map_idx(f1, s1); e_i2 = map_idx(f2, s2); e_id = map_idx(fd, sd);
      e_err = is_bad(f1, s1) || is_bad(f2, s2) || is_bad(fd, sd);
      e_z1 = 0; e_z2 = 0; e_we = 0; e_clo = 0; e_chi = 0; e_gfx = 0;
      if (e_err) m_trap = 6;
      else begin
        m_trap = 0;
        e_z1 = (s1 != 0) && !((e_i1 >= 32) ? m_hi : m_lo);
        e_z2 = (s2 != 0) && !((e_i2 >= 32) ? m_hi : m_lo);
        e_we = (sd != 0);
        if (e_we) begin
          e_gfx = !m_en;
          if (!m_en) begin m_lo = 0; m_hi = 0; m_en = 1; end
          up = (e_id >= 32);
          if (up) begin e_chi = !m_hi; m_hi = 1; end
          else    begin e_clo = !m_lo; m_lo = 1; end
        end
      end
    end else if (rsp_ready) e_valid = 0;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_ready == (!e_valid || rsp_ready), "R9 req_ready", req_ready, !e_valid || rsp_ready);
      check(rsp_valid == e_valid, "R9 rsp_valid", rsp_valid, e_valid);
      check(fp_en == m_en, "R6 fp_en", fp_en, m_en);
      check(dirty_lo == m_lo, "R7 dirty_lo", dirty_lo, m_lo);
      check(dirty_hi == m_hi, "R7 dirty_hi", dirty_hi, m_hi);
      check(int'(trap_type) == m_trap, "R4 trap_type", trap_type, m_trap);
      if (e_valid) begin
        check(int'(rsp_rs1_idx) == e_i1, "R1/R2 rs1_idx", rsp_rs1_idx, e_i1);
        check(int'(rsp_rs2_idx) == e_i2, "R1/R2 rs2_idx", rsp_rs2_idx, e_i2);
        check(int'(rsp_rd_idx) == e_id, "R1/R2 rd_idx", rsp_rd_idx, e_id);
        check(rsp_rs1_zero == e_z1, "R5 rs1_zero", rsp_rs1_zero, e_z1);
        check(rsp_rs2_zero == e_z2, "R5 rs2_zero", rsp_rs2_zero, e_z2);
        check(rsp_rd_we == e_we, "R8 rd_we", rsp_rd_we, e_we);
        check(rsp_clr_lo == e_clo, "R7 clr_lo", rsp_clr_lo, e_clo);
        check(rsp_clr_hi == e_chi, "R7 clr_hi", rsp_clr_hi, e_chi);
        check(rsp_gfx_clr == e_gfx, "R6 gfx_clr", rsp_gfx_clr, e_gfx);
        check(rsp_err == e_err, "R3 err", rsp_err, e_err);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (bp_on) rsp_ready = ($urandom_range(0, 1) == 1);
    else rsp_ready = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(int rd, int rs1, int rs2);
    logic [31:0] w = '0;
    w[29:25] = 5'(rd); w[18:14] = 5'(rs1); w[4:0] = 5'(rs2);
    return w;
  endfunction

  task automatic issue(logic [31:0] w, int s1, int s2, int sd);
    @(negedge clk); #1;
    req_valid = 1; req_insn = w;
    req_sz_rs1 = 2'(s1); req_sz_rs2 = 2'(s2); req_sz_rd = 2'(sd);
    do @(negedge clk); while (!m_acc);
    #1 req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R10 rsp_valid", rsp_valid, 0);
    check(fp_en == 0 && dirty_lo == 0 && dirty_hi == 0, "R10 state", {fp_en, dirty_lo, dirty_hi}, 0);
    check(trap_type == 0, "R10 trap", trap_type, 0);
    rst_n = 1;
    // first source read of a clean lower half reads zero
    issue(mk(0, 3, 0), 1, 0, 0);
    check(rsp_rs1_idx == 3 && rsp_rs1_zero == 1, "R5 clean read", rsp_rs1_zero, 1);
    // double destination field 5 goes to index 36, first write enables the unit
    issue(mk(5, 0, 0), 0, 0, 2);
    check(rsp_rd_idx == 36, "R2 double odd", rsp_rd_idx, 36);
    check(rsp_gfx_clr == 1 && rsp_clr_hi == 1, "R6 first write", {rsp_gfx_clr, rsp_clr_hi}, 3);
    // quad destination field 8 -> index 8, lower half cleared
    issue(mk(8, 0, 0), 0, 0, 3);
    check(rsp_rd_idx == 8 && rsp_clr_lo == 1 && rsp_gfx_clr == 0, "R7 lower clear", rsp_clr_lo, 1);
    // quad source with field bit 1 set aborts
    issue(mk(4, 0, 2), 0, 3, 1);
    check(rsp_err == 1 && trap_type == 6 && rsp_rd_we == 0, "R3 invalid quad", trap_type, 6);
    // no operands at all
    issue(mk(31, 31, 31), 0, 0, 0);
    check(rsp_err == 0 && rsp_rd_we == 0 && trap_type == 0, "R8 none", trap_type, 0);
    // write into already dirty lower half: no clear
    issue(mk(7, 0, 0), 0, 0, 1);
    check(rsp_rd_we == 1 && rsp_clr_lo == 0, "R7 dirty half", rsp_clr_lo, 0);
    issue(mk(0, 1, 0), 2, 0, 0);
    check(rsp_rs1_idx == 32 && rsp_rs1_zero == 0, "R5 upper dirty read", rsp_rs1_zero, 0);
    bp_on = 1;
    for (int i = 0; i < 3000; i++)
      issue($urandom, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
    bp_on = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule